// File: doc/BRIEF.md
# Count/Compare Interval Timer

This block keeps a free-running 32-bit counter and a 32-bit match register, in the manner of a processor's built-in interval timer. On each enabled tick the counter advances by one. When an increment carries the counter onto the value in the match register, a timer interrupt becomes pending. The interrupt drives one of eight interrupt lines, and the line is picked by a 3-bit routing input. The pending state holds until software writes the match register again.

A freeze input stops the counter and blocks match detection. Software can write the counter at any time, whether or not the counter is frozen. A revision-2 enable input adds a readable timer-interrupt status bit. The match sets this bit, and a write of the match register clears it. Software normally rewrites the match register inside its interrupt handler. That write both acknowledges the interrupt and schedules the next one.

Top module: `intervalTimer`

## Requirements
- R1: After reset the counter reads 1, the match register holds 0, the status bit is 0 and all eight interrupt lines are low.
- R2: On a clock edge where the tick input is high, the freeze input is low and no counter write is present, the counter increases by one modulo 2^32, so 0xFFFFFFFF becomes 0.
- R3: While the freeze input is high, the counter holds its value on ticks, and no match interrupt is raised.
- R4: A counter write loads its data on the next edge, whether or not the counter is frozen, and takes priority over an increment on the same edge. A written value equal to the match register does not raise an interrupt.
- R5: An increment that makes the counter equal to the match register sets the interrupt pending. The counter shows the matching value and the interrupt line is high after that same edge.
- R6: When revision-2 behaviour is enabled, a match also sets the status bit. When it is disabled, a match leaves the status bit unchanged.
- R7: A match-register write loads the new value and clears the pending interrupt. It wins over a match on the same edge.
- R8: A match-register write with revision-2 behaviour enabled clears the status bit. With it disabled, the status bit keeps its value.
- R9: While an interrupt is pending, only interrupt line number irqSel (bit irqSel of irqLines) is high, and the line follows irqSel at once. With nothing pending, all lines are low.
- R10: A pending interrupt stays asserted across any number of further ticks, counter writes and freezes until the match register is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tickEn | input | 1 | Count-enable tick |
| countFreeze | input | 1 | Holds the counter and blocks match detection |
| cntWrEn | input | 1 | Counter write strobe |
| cntWrData | input | 32 | Counter write data |
| cmpWrEn | input | 1 | Match-register write strobe |
| cmpWrData | input | 32 | Match-register write data |
| rev2En | input | 1 | Enables the timer-interrupt status bit behaviour |
| irqSel | input | 3 | Selects which interrupt line the timer drives |
| count | output | 32 | Current counter value |
| timerFlag | output | 1 | Timer-interrupt status bit |
| irqLines | output | 8 | Interrupt lines, at most one high |

## Verification
The hardest situation to reach is an increment that lands exactly on the match value. With random 32-bit values this almost never happens. It is harder still when it has to coincide with a freeze, a counter write or a match-register write on the same edge. The stimulus therefore writes the counter or the match register with values a few steps away from each other, which makes matches frequent. It then adds random ticks, freezes and colliding writes. Directed sequences cover the wrap at 0xFFFFFFFF, a match exactly at the wrap to zero, and a full sweep of the routing field while an interrupt is pending.

// File: rtl/timerPkg.sv
package timerPkg;
  typedef struct packed {
    logic loadCount;
    logic incCount;
    logic loadCmp;
    logic setPend;
    logic clrPend;
    logic setFlag;
    logic clrFlag;
  } timerStrobes_t;
endpackage

// File: rtl/timerDatapath.sv
module timerDatapath
  import timerPkg::*;
#(
  parameter int WIDTH = 32,
  parameter logic [WIDTH-1:0] RESET_COUNT = 1,
  parameter logic [WIDTH-1:0] RESET_CMP = 0
) (
  input  logic             clk,
  input  logic             rstN,
  input  timerStrobes_t    strb,
  input  logic [WIDTH-1:0] cntWrData,
  input  logic [WIDTH-1:0] cmpWrData,
  output logic [WIDTH-1:0] count,
  output logic             incHit
);
  logic [WIDTH-1:0] compare;
  logic [WIDTH-1:0] countPlus;

  assign countPlus = count + WIDTH'(1);
  assign incHit    = (countPlus == compare);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      count <= RESET_COUNT;
    end else if (strb.loadCount) begin
      count <= cntWrData;
    end else if (strb.incCount) begin
      count <= countPlus;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      compare <= RESET_CMP;
    end else if (strb.loadCmp) begin
      compare <= cmpWrData;
    end
  end

  // R2
  inc_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.incCount && !strb.loadCount) |=> count == $past(count) + WIDTH'(1));

  // R4
  load_count_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadCount |=> count == $past(cntWrData));
endmodule

// File: rtl/timerControl.sv
module timerControl
  import timerPkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic          tickEn,
  input  logic          countFreeze,
  input  logic          cntWrEn,
  input  logic          cmpWrEn,
  input  logic          rev2En,
  input  logic          incHit,
  output timerStrobes_t strb,
  output logic          pending,
  output logic          timerFlag
);
  logic matchNow;

  always_comb begin
    strb           = '0;
    strb.loadCount = cntWrEn;
    strb.incCount  = tickEn && !countFreeze && !cntWrEn;
    strb.loadCmp   = cmpWrEn;
    matchNow       = strb.incCount && incHit;
    strb.setPend   = matchNow && !cmpWrEn;
    strb.clrPend   = cmpWrEn;
    strb.setFlag   = strb.setPend && rev2En;
    strb.clrFlag   = cmpWrEn && rev2En;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pending <= 1'b0;
    end else if (strb.clrPend) begin
      pending <= 1'b0;
    end else if (strb.setPend) begin
      pending <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      timerFlag <= 1'b0;
    end else if (strb.clrFlag) begin
      timerFlag <= 1'b0;
    end else if (strb.setFlag) begin
      timerFlag <= 1'b1;
    end
  end

  // R10
  pend_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pending && !cmpWrEn) |=> pending);

  // R3
  freeze_no_irq_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!pending && countFreeze && !cmpWrEn) |=> !pending);

  // R6
  flag_noRev2_chk: assert property (@(posedge clk) disable iff (!rstN)
    !rev2En |=> $stable(timerFlag));
endmodule

// File: rtl/intervalTimer.sv
module intervalTimer
  import timerPkg::*;
#(
  parameter int WIDTH = 32,
  parameter int LINES = 8,
  localparam int SEL_W = $clog2(LINES)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tickEn,
  input  logic             countFreeze,
  input  logic             cntWrEn,
  input  logic [WIDTH-1:0] cntWrData,
  input  logic             cmpWrEn,
  input  logic [WIDTH-1:0] cmpWrData,
  input  logic             rev2En,
  input  logic [SEL_W-1:0] irqSel,
  output logic [WIDTH-1:0] count,
  output logic             timerFlag,
  output logic [LINES-1:0] irqLines
);
  timerStrobes_t strb;
  logic          incHit;
  logic          pending;

  timerDatapath #(
    .WIDTH(WIDTH),
    .RESET_COUNT(WIDTH'(1)),
    .RESET_CMP(WIDTH'(0))
  ) i_datapath (
    .clk(clk),
    .rstN(rstN),
    .strb(strb),
    .cntWrData(cntWrData),
    .cmpWrData(cmpWrData),
    .count(count),
    .incHit(incHit)
  );

  timerControl i_control (
    .clk(clk),
    .rstN(rstN),
    .tickEn(tickEn),
    .countFreeze(countFreeze),
    .cntWrEn(cntWrEn),
    .cmpWrEn(cmpWrEn),
    .rev2En(rev2En),
    .incHit(incHit),
    .strb(strb),
    .pending(pending),
    .timerFlag(timerFlag)
  );

  for (genvar g = 0; g < LINES; g++) begin : g_route
    assign irqLines[g] = pending && (irqSel == SEL_W'(g));
  end

  // R9
  route_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(irqLines));

  // R3
  freeze_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (countFreeze && !cntWrEn) |=> $stable(count));

  // R7
  cmp_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmpWrEn |=> irqLines == '0);

  // R8
  flag_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmpWrEn && rev2En) |=> !timerFlag);
endmodule

// File: tb/test_intervalTimer.sv
module test_intervalTimer;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        tickEn = 1'b0, countFreeze = 1'b0, cntWrEn = 1'b0, cmpWrEn = 1'b0, rev2En = 1'b0;
  logic [31:0] cntWrData = '0, cmpWrData = '0;
  logic [2:0]  irqSel = '0;
  logic [31:0] count;
  logic        timerFlag;
  logic [7:0]  irqLines;

  int nTests = 0;
  int nFail  = 0;
  logic [31:0] mCount, mCmp;
  logic        mPend, mFlag;

  intervalTimer i_intervalTimer (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .countFreeze(countFreeze),
    .cntWrEn(cntWrEn), .cntWrData(cntWrData), .cmpWrEn(cmpWrEn),
    .cmpWrData(cmpWrData), .rev2En(rev2En), .irqSel(irqSel),
    .count(count), .timerFlag(timerFlag), .irqLines(irqLines)
  );

  always #4 clk = ~clk;

  function automatic logic [7:0] expLines(logic p, logic [2:0] s);
    return p ? (8'b1 << s) : 8'h00;
  endfunction

  task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // One clock: inputs already driven; update model, cross edge, check.
  task automatic step(string tag);
    logic match;
    logic [31:0] nxt;
    string tC, tI, tF;
    nxt = mCount + 32'd1;
    match = tickEn && !countFreeze && !cntWrEn && (nxt == mCmp);
    if (cntWrEn) mCount = cntWrData;
    else if (tickEn && !countFreeze) mCount = nxt;
    if (cmpWrEn) begin
      mCmp = cmpWrData; mPend = 1'b0;
      if (rev2En) mFlag = 1'b0;
    end else if (match) begin
      mPend = 1'b1;
      if (rev2En) mFlag = 1'b1;
    end
    tC = (tag != "") ? tag : cntWrEn ? "R4" : countFreeze ? "R3" : "R2";
    tI = (tag != "") ? tag : cmpWrEn ? "R7" : match ? "R5" : "R10";
    tF = (tag != "") ? tag : cmpWrEn ? "R8" : "R6";
    @(posedge clk);
    #2;
    check(tC, "count", count, mCount);
    check(tI, "irqLines", {24'h0, irqLines}, {24'h0, expLines(mPend, irqSel)});
    check(tF, "timerFlag", {31'h0, timerFlag}, {31'h0, mFlag});
    @(negedge clk);
    cntWrEn = 1'b0; cmpWrEn = 1'b0;
  endtask

  task automatic writeCount(logic [31:0] v, string tag);
    cntWrEn = 1'b1; cntWrData = v; tickEn = 1'b0; countFreeze = 1'b0;
    step(tag);
  endtask

  task automatic writeCmp(logic [31:0] v, string tag);
    cmpWrEn = 1'b1; cmpWrData = v; tickEn = 1'b0;
    step(tag);
  endtask

  task automatic ticks(int n, string tag);
    for (int i = 0; i < n; i++) begin
      tickEn = 1'b1;
      step(tag);
    end
    tickEn = 1'b0;
  endtask

  initial begin
    #(8 * 150000);
    nTests++; nFail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    mCount = 32'd1; mCmp = 32'd0; mPend = 1'b0; mFlag = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1;
    // R1 reset state
    check("R1", "count", count, 32'd1);
    check("R1", "irqLines", {24'h0, irqLines}, 32'd0);
    check("R1", "timerFlag", {31'h0, timerFlag}, 32'd0);
    @(negedge clk);

    // R5 match at wrap with reset compare value 0, rev2 on (R6)
    rev2En = 1'b1; irqSel = 3'd5;
    writeCount(32'hFFFF_FFFD, "R4");
    ticks(3, "R5");
    check("R6", "flag after rev2 match", {31'h0, timerFlag}, 32'd1);
    // R10 pending holds through ticks, writes, freeze
    ticks(5, "R10");
    writeCount(32'h1234, "R10");
    countFreeze = 1'b1; ticks(2, "R10"); countFreeze = 1'b0;
    // R9 routing sweep
    for (int s = 0; s < 8; s++) begin
      irqSel = 3'(s);
      #1;
      check("R9", "route", {24'h0, irqLines}, {24'h0, 8'b1 << s});
    end
    // R8 without rev2 the flag survives a compare write
    rev2En = 1'b0;
    writeCmp(32'h100, "R8");
    check("R8", "flag kept", {31'h0, timerFlag}, 32'd1);
    rev2En = 1'b1;
    writeCmp(32'h100, "R8");
    // R2 wrap
    writeCount(32'hFFFF_FFFF, "R2");
    ticks(1, "R2");
    check("R2", "wrap", count, 32'd0);
    // R3 freeze blocks match
    writeCount(32'hFF, "R4");
    countFreeze = 1'b1; ticks(4, "R3"); countFreeze = 1'b0;
    // R4 write equal to compare, frozen, no irq
    countFreeze = 1'b1; cntWrEn = 1'b1; cntWrData = 32'h100; step("R4"); countFreeze = 1'b0;
    ticks(1, "R4");
    // R7 compare write collides with match
    writeCount(32'h1FF, "R4");
    writeCmp(32'h200, "R7");
    tickEn = 1'b1; cmpWrEn = 1'b1; cmpWrData = 32'h300; step("R7"); tickEn = 1'b0;
    // R6 without rev2 a match leaves flag clear
    rev2En = 1'b0;
    writeCount(32'h2FE, "R4");
    ticks(2, "R6");

    // constrained random phase
    for (int n = 0; n < 20000; n++) begin
      if (n % 500 == 0) rev2En = $urandom_range(0, 1) == 1;
      tickEn      = $urandom_range(0, 9) < 7;
      countFreeze = $urandom_range(0, 9) < 1;
      irqSel      = 3'($urandom_range(0, 7));
      cntWrEn     = $urandom_range(0, 19) == 0;
      cntWrData   = mCmp - 32'($urandom_range(0, 6));
      cmpWrEn     = $urandom_range(0, 29) == 0;
      cmpWrData   = mCount + 32'($urandom_range(0, 8));
      step("");
    end

    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule